// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is a binary up-counter whose register changes only on the rising clock edge. On each edge it does exactly one of four things. It clears to zero, loads a parallel word, advances by one, or keeps its value. Two active-low controls select clearing and loading. Two active-high enables must both be set for the count to advance.

One of the two enables is a carry input, and it also gates the terminal flag. Several instances can therefore be chained. The terminal flag of one stage drives the carry enable of the next. The shared parallel enable then acts as a global count enable. The terminal flag is combinational. It is high only while the count holds all ones and the carry enable is high.

Internally a decoder picks one of four named operations each cycle:

- CLEAR is chosen when the clear input is low.
- LOAD is chosen when clear is inactive and the load input is low.
- COUNT is chosen when both enables are high.
- HOLD covers every other case.

A next-value stage maps that operation onto the register. The transitions are:

- CLEAR sends the count to 0.
- LOAD sends it to the data word.
- COUNT sends it to count+1, and the all-ones value wraps to 0.
- HOLD leaves it unchanged.

Top module: `cascade_counter`

## Requirements
- R1: Before any clock edge has acted, the count output reads 0.
- R2: With clr_n low at a rising edge, the count becomes 0 whatever load_n, din, en_par and en_carry are.
- R3: With clr_n high and load_n low at a rising edge, the count becomes din whatever en_par and en_carry are.
- R4: With clr_n and load_n high and both en_par and en_carry high at a rising edge, the count becomes the previous count plus one.
- R5: With clr_n and load_n high and en_par or en_carry low at a rising edge, the count keeps its previous value.
- R6: term is 1 exactly when en_carry is 1 and every bit of count is 1; otherwise it is 0.
- R7: term responds to a change of en_carry in the same cycle, before any clock edge.
- R8: Advancing from the all-ones count (15 at width 4) gives 0, and term is high while the count is all ones and en_carry is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for all state |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous parallel load, active low |
| din | input | W | Parallel data word to load |
| en_par | input | 1 | Parallel count enable |
| en_carry | input | 1 | Carry-in count enable; also gates term |
| count | output | W | Current count value |
| term | output | 1 | Terminal flag: all-ones count while en_carry is high |

## Verification
The bench builds the counter at its default width of four bits. At that width the whole space can be swept:

- every one of the 16 starting counts,
- every one of the 16 settings of the four controls,
- every one of the 16 data words.

Each of these 4096 vectors is checked against an arithmetic model. The sweep covers the wrap from 15 to 0, the precedence of clear over load over count, and the terminal flag with the carry enable both high and low.

// File: rtl/cascade_counter_pkg.sv
package cascade_counter_pkg;

    // Operation selected for the coming clock edge, listed in priority order.
    typedef enum logic [1:0] {
        OP_CLEAR = 2'd0,
        OP_LOAD  = 2'd1,
        OP_COUNT = 2'd2,
        OP_HOLD  = 2'd3
    } ctr_op_t;

endpackage

// File: rtl/ctr_op_decode.sv
module ctr_op_decode
    import cascade_counter_pkg::*;
(
    input  logic    clr_n,
    input  logic    load_n,
    input  logic    en_par,
    input  logic    en_carry,
    output ctr_op_t op
);

    // Fixed precedence: clear, then load, then count; anything else holds.
    always_comb begin
        if (!clr_n) begin
            op = OP_CLEAR;
        end else if (!load_n) begin
            op = OP_LOAD;
        end else if (en_par && en_carry) begin
            op = OP_COUNT;
        end else begin
            op = OP_HOLD;
        end
    end

endmodule

// File: rtl/ctr_next_value.sv
module ctr_next_value
    import cascade_counter_pkg::*;
#(
    parameter int W = 4
) (
    input  ctr_op_t        op,
    input  logic [W-1:0]   cur,
    input  logic [W-1:0]   din,
    output logic [W-1:0]   nxt
);

    localparam logic [W-1:0] ONE = W'(1);

    always_comb begin
        unique case (op)
            OP_CLEAR: nxt = '0;
            OP_LOAD:  nxt = din;
            OP_COUNT: nxt = cur + ONE;   // natural wrap at all ones
            OP_HOLD:  nxt = cur;
        endcase
    end

endmodule

// File: rtl/ctr_terminal_detect.sv
module ctr_terminal_detect #(
    parameter int W = 4
) (
    input  logic [W-1:0] cur,
    input  logic         en_carry,
    output logic         term
);

    // Ripple AND chain seeded by the carry enable; stage i covers bits 0..i.
    logic [W:0] chain;
    assign chain[0] = en_carry;

    for (genvar i = 0; i < W; i++) begin : g_and
        assign chain[i+1] = chain[i] & cur[i];
    end

    assign term = chain[W];

endmodule

// File: rtl/cascade_counter.sv
module cascade_counter
    import cascade_counter_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic         load_n,
    input  logic [W-1:0] din,
    input  logic         en_par,
    input  logic         en_carry,
    output logic [W-1:0] count,
    output logic         term
);

    ctr_op_t      op;
    logic [W-1:0] count_q = '0;   // defined start-up value
    logic [W-1:0] count_d;

    ctr_op_decode u_dec (
        .clr_n    (clr_n),
        .load_n   (load_n),
        .en_par   (en_par),
        .en_carry (en_carry),
        .op       (op)
    );

    ctr_next_value #(.W(W)) u_nxt (
        .op  (op),
        .cur (count_q),
        .din (din),
        .nxt (count_d)
    );

    // State register: the only sequential process in the block.
    always_ff @(posedge clk) begin
        count_q <= count_d;
    end

    ctr_terminal_detect #(.W(W)) u_term (
        .cur      (count_q),
        .en_carry (en_carry),
        .term     (term)
    );

    assign count = count_q;

endmodule

// File: rtl/cascade_counter_chk.sv
module cascade_counter_chk #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         clr_n,
    input logic         load_n,
    input logic [W-1:0] din,
    input logic         en_par,
    input logic         en_carry,
    input logic [W-1:0] count,
    input logic         term
);

    logic armed = 1'b0;
    always_ff @(posedge clk) armed <= 1'b1;

    // R2
    clear_wins_chk: assert property (@(posedge clk) disable iff (!armed)
        !clr_n |=> count == '0);

    // R3
    load_wins_chk: assert property (@(posedge clk) disable iff (!armed)
        (clr_n && !load_n) |=> count == $past(din));

    // R4
    advance_chk: assert property (@(posedge clk) disable iff (!armed)
        (clr_n && load_n && en_par && en_carry) |=> count == $past(count) + W'(1));

    // R5
    hold_chk: assert property (@(posedge clk) disable iff (!armed)
        (clr_n && load_n && !(en_par && en_carry)) |=> $stable(count));

    // R6
    term_needs_carry_chk: assert property (@(posedge clk) disable iff (!armed)
        term |-> en_carry);

    // R6
    term_needs_full_chk: assert property (@(posedge clk) disable iff (!armed)
        term |-> (count == {W{1'b1}}));

endmodule

bind cascade_counter cascade_counter_chk #(.W(W)) chk_i (
    .clk      (clk),
    .clr_n    (clr_n),
    .load_n   (load_n),
    .din      (din),
    .en_par   (en_par),
    .en_carry (en_carry),
    .count    (count),
    .term     (term)
);

// File: tb/cascade_counter_test.sv
module cascade_counter_test;

    localparam int W    = 4;
    localparam int SPAN = 1 << W;
    localparam int FULL = SPAN - 1;

    logic         clk = 1'b0;
    logic         clr_n = 1'b1;
    logic         load_n = 1'b1;
    logic [W-1:0] din = '0;
    logic         en_par = 1'b0;
    logic         en_carry = 1'b1;
    logic [W-1:0] count;
    logic         term;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;   // 4 ns period

    cascade_counter #(.W(W)) uut (
        .clk      (clk),
        .clr_n    (clr_n),
        .load_n   (load_n),
        .din      (din),
        .en_par   (en_par),
        .en_carry (en_carry),
        .count    (count),
        .term     (term)
    );

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        #1;
        // R1: before the first edge
        check("R1", int'(count), 0);
        check("R6", int'(term), 0);

        for (int start = 0; start < SPAN; start++) begin
            for (int ctl = 0; ctl < 16; ctl++) begin
                for (int d = 0; d < SPAN; d++) begin
                    int  exp;
                    bit  c, l, p, k;
                    string tag;

                    // preload the starting count
                    @(negedge clk);
                    clr_n = 1'b1; load_n = 1'b0; din = W'(start);
                    en_par = 1'b0; en_carry = 1'b0;
                    @(negedge clk);
                    check("R3", int'(count), start);

                    c = ctl[3]; l = ctl[2]; p = ctl[1]; k = ctl[0];
                    clr_n = c; load_n = l; en_par = p; en_carry = k;
                    din = W'(d);
                    #1;
                    // R6 / R7: combinational flag, no edge since en_carry moved
                    check((start == FULL) ? "R8" : "R7", int'(term),
                          (k && start == FULL) ? 1 : 0);

                    if (!c) begin
                        exp = 0; tag = "R2";
                    end else if (!l) begin
                        exp = d; tag = "R3";
                    end else if (p && k) begin
                        exp = (start + 1) % SPAN;
                        tag = (start == FULL) ? "R8" : "R4";
                    end else begin
                        exp = start; tag = "R5";
                    end
                    @(negedge clk);
                    check(tag, int'(count), exp);
                    check("R6", int'(term), (k && exp == FULL) ? 1 : 0);
                end
            end
        end
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            finish_run();
        end
    end

endmodule